// File: doc/BRIEF.md
# Transposed Constant-Coefficient FIR Filter

This block is a 16-tap finite impulse response filter built in transposed form. Every tap owns a multiplier by a constant that is fixed at elaboration, an adder, and a partial-sum register. Each accepted input sample goes to all sixteen multipliers at once. Each tap adds its product to the partial sum held by the tap after it and stores the result. The register of tap 0 is the filter output.

The filter takes one signed sample per cycle, marked by a valid strobe. One cycle later it gives a full-precision signed result with its own valid strobe. No result is rounded, scaled or truncated. Cycles without a valid input leave the filter's history untouched, so the output depends only on the sequence of accepted samples.

Top module: `xfir_top`

## Requirements
- R1: The coefficient set is, from tap 0 to tap 15: -3, -6, 9, 21, -20, -41, 78, 127, 127, 78, -41, -20, 21, 9, -6, -128. Each coefficient is a constant inside the block.
- R2: `inSample` is read as 8-bit two's complement. Each result is the exact sum over k = 0..15 of h(k)·x(n-k), where x(n) is the newest accepted sample. The result is given as a 20-bit two's complement value with no rounding or scaling.
- R3: When `inValid` is high at a rising clock edge, `outValid` is high and `outSample` holds the new result from that edge until the next edge.
- R4: When `inValid` is low at an edge, `inSample` is ignored, `outValid` goes low, `outSample` keeps its value, and no partial sum changes. A gap between samples does not alter later results.
- R5: Reset (`rstN` low, asynchronous) clears every partial sum, `outSample` and `outValid`. The first result after reset is therefore h(0)·x.
- R6: Extreme inputs (-128 and 127) give exact results with no wrap-around. This includes a sustained -128 and a sequence whose signs match the coefficient signs.
- R7: A single unit impulse followed by zeros gives h(0), h(1), ..., h(15) in that order, and then 0.
- R8: Samples on consecutive cycles give one result per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks `inSample` as a sample to accept |
| inSample | input | 8 | Signed input sample |
| outValid | output | 1 | Marks a new result on `outSample` |
| outSample | output | 20 | Signed full-precision filter result |

## Verification
The bench builds the filter with its default parameters: 8-bit samples, 8-bit coefficients and 16 taps. This gives a 20-bit output, so the whole partial-sum chain is exercised. It also means the -128 coefficient at the last tap and the 127 coefficients in the middle meet full-scale inputs. These settings reach the largest possible magnitude of the result and check that no bit is lost. Results are compared after impulses, full-scale steps, sign-matched worst cases, pseudo-random streams with idle gaps, and a reset partway through a run.

// File: rtl/xfir_pkg.sv
`timescale 1ns/1ps
package xfir_pkg;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic load;   // accept the broadcast sample into every tap
  } xfirStrobe_t;

  localparam int COEF_SET_LEN = 16;

  // Constant tap weights, h(0) first (R1)
  function automatic int tapCoef(input int idx);
    case (idx % COEF_SET_LEN)
      0:  return -3;
      1:  return -6;
      2:  return 9;
      3:  return 21;
      4:  return -20;
      5:  return -41;
      6:  return 78;
      7:  return 127;
      8:  return 127;
      9:  return 78;
      10: return -41;
      11: return -20;
      12: return 21;
      13: return 9;
      14: return -6;
      default: return -128;
    endcase
  endfunction

endpackage

// File: rtl/xfir_ctrl.sv
`timescale 1ns/1ps
module xfir_ctrl
  import xfir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output xfirStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe      = '0;
    strobe.load = inValid;
  end

  // The result register updates on the same edge, so valid follows one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/xfir_tap.sv
`timescale 1ns/1ps
module xfir_tap #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 20,
  parameter int COEF   = 0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     load,
  input  logic [DATA_W-1:0]        sample,
  input  logic signed [ACC_W-1:0]  chainIn,
  output logic signed [ACC_W-1:0]  chainOut
);

  localparam logic signed [COEF_W-1:0] COEF_NARROW = COEF_W'(COEF);
  localparam logic signed [ACC_W-1:0]  COEF_WIDE   =
    {{(ACC_W-COEF_W){COEF_NARROW[COEF_W-1]}}, COEF_NARROW};

  logic signed [ACC_W-1:0] sampleWide;
  logic signed [ACC_W-1:0] product;
  logic signed [ACC_W-1:0] partial;

  assign sampleWide = {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};
  assign product    = sampleWide * COEF_WIDE;   // constant multiplier
  assign partial    = product + chainIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     chainOut <= '0;
    else if (load) chainOut <= partial;
  end

endmodule

// File: rtl/xfir_datapath.sv
`timescale 1ns/1ps
module xfir_datapath
  import xfir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 16,
  parameter int ACC_W  = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xfirStrobe_t             strobe,
  input  logic [DATA_W-1:0]       sample,
  output logic signed [ACC_W-1:0] result
);

  // chain[i] is the register of tap i; chain[TAPS] is the zero feed into the last tap
  logic signed [ACC_W-1:0] chain [TAPS+1];

  assign chain[TAPS] = '0;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    xfir_tap #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W),
      .COEF  (tapCoef(i))
    ) u_tap (
      .clk     (clk),
      .rstN    (rstN),
      .load    (strobe.load),
      .sample  (sample),
      .chainIn (chain[i+1]),
      .chainOut(chain[i])
    );
  end

  assign result = chain[0];

endmodule

// File: rtl/xfir_top.sv
`timescale 1ns/1ps
module xfir_top
  import xfir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 16,
  localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inSample,
  output logic              outValid,
  output logic [ACC_W-1:0]  outSample
);

  xfirStrobe_t             strobe;
  logic signed [ACC_W-1:0] result;

  xfir_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  xfir_datapath #(
    .DATA_W(DATA_W),
    .COEF_W(COEF_W),
    .TAPS  (TAPS),
    .ACC_W (ACC_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .sample(inSample),
    .result(result)
  );

  assign outSample = result;

endmodule

// File: rtl/xfir_checker.sv
`timescale 1ns/1ps
module xfir_checker
  import xfir_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 16,
  parameter int ACC_W  = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inSample,
  input logic              outValid,
  input logic [ACC_W-1:0]  outSample
);

  localparam logic signed [ACC_W-1:0] H0 = ACC_W'(tapCoef(0));

  logic                    firstPending;
  logic signed [ACC_W-1:0] firstRef;

  assign firstRef = {{(ACC_W-DATA_W){inSample[DATA_W-1]}}, inSample} * H0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        firstPending <= 1'b1;
    else if (inValid) firstPending <= 1'b0;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                          // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                        // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outSample));                               // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rstN) |-> (outSample == '0 && !outValid));                // R5

  AST_FIRST_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && firstPending) |=> (outSample == $past(firstRef)));  // R5

endmodule

bind xfir_top xfir_checker #(
  .DATA_W(DATA_W),
  .COEF_W(COEF_W),
  .TAPS  (TAPS),
  .ACC_W (ACC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inSample (inSample),
  .outValid (outValid),
  .outSample(outSample)
);

// File: tb/xfir_top_test.sv
`timescale 1ns/1ps
module xfir_top_test;

  localparam int DW = 8;
  localparam int AW = 20;
  localparam int NT = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inSample = '0;
  logic          outValid;
  logic [AW-1:0] outSample;

  always #4 clk = ~clk;   // 125 MHz

  xfir_top uut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSample (inSample),
    .outValid (outValid),
    .outSample(outSample)
  );

  // Coefficients as written in R1
  int coefTab [NT] = '{-3, -6, 9, 21, -20, -41, 78, 127, 127, 78, -41, -20, 21, 9, -6, -128};

  int    hist [NT];
  int    expQ [$];
  string tagQ [$];
  int    checks = 0;
  int    errors = 0;
  int    lastOut = 0;
  bit    monOn = 1'b0;
  int    seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 32'h00ff_ffff;
  endfunction

  // Driver: presents one sample and queues its expected result
  task automatic send(input int x, input string tag);
    int acc;
    @(negedge clk);
    inValid  = 1'b1;
    inSample = DW'(x);
    for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += coefTab[k] * hist[k];
    expQ.push_back(acc);
    tagQ.push_back(tag);
  endtask

  // Idle cycles with junk on the sample bus (must be ignored, R4)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid  = 1'b0;
      inSample = DW'(nextRand());
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    monOn   = 1'b0;
    rstN    = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0 && outSample == '0, "R5 reset clears output",
          int'($signed(outSample)) + (outValid ? 1000000 : 0), 0);
    for (int k = 0; k < NT; k++) hist[k] = 0;
    lastOut = 0;
    rstN    = 1'b1;
    monOn   = 1'b1;
  endtask

  // Monitor: scoreboard compare and idle-hold check
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected result", int'($signed(outSample)), 0);
        end else begin
          int    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(int'($signed(outSample)) == e, t, int'($signed(outSample)), e);
          lastOut = e;
        end
      end else begin
        check(int'($signed(outSample)) == lastOut, "R4 output held while idle",
              int'($signed(outSample)), lastOut);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    doReset();

    // R7: impulse response, then trailing zero (R1 coefficient order)
    send(1, "R7 impulse");
    for (int i = 0; i < NT; i++) send(0, "R7 impulse tail");
    idle(2);

    // R4: gaps must not shift history
    send(5, "R4 before gap");
    idle(3);
    send(-7, "R4 after gap");
    idle(1);
    send(11, "R4 after short gap");
    for (int i = 0; i < NT; i++) send(0, "R4 flush");
    idle(2);

    // R6: sustained full negative step, back to back (R8)
    for (int i = 0; i < NT + 4; i++) send(-128, "R6 negative step");
    // R6: signs matched to coefficients, largest magnitude
    for (int j = 0; j < NT; j++) send(coefTab[NT-1-j] < 0 ? -128 : 127, "R6 sign matched");
    for (int j = 0; j < NT; j++) send(coefTab[NT-1-j] < 0 ? 127 : -128, "R6 sign opposed");
    send(127, "R6 positive full scale");
    idle(2);

    // R2 and R8: pseudo-random stream with occasional gaps
    for (int i = 0; i < 300; i++) begin
      int r;
      r = nextRand();
      send((r & 255) - 128, "R2 random stream");
      if ((r & 32'h700) == 0) idle(1);
    end
    idle(2);

    // R5: reset partway through a run, first result is h(0)*x
    for (int i = 0; i < 5; i++) send(100 - 30 * i, "R8 pre reset");
    idle(2);
    doReset();
    send(5, "R5 first after reset");
    send(-1, "R5 second after reset");
    idle(3);

    check(expQ.size() == 0, "R3 all results delivered", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule